// File: doc/BRIEF.md
# Wiper Position Counter with Multiple Load Sources

This block holds the 8-bit volatile position of a digitally controlled potentiometer wiper and turns it into a one-hot select across 256 taps. Index 0 selects the low terminal and index 255 selects the high terminal. The serial command decoder that sits in front of the block changes the position in four ways. It can write a received byte directly. It can transfer the contents of one of the four bank-0 data registers. It can step the position up or down by one tap for each serial clock high pulse while an open-ended step command stays active. The fourth way is automatic: on the first clock after reset, the block recalls bank-0 register 0.

The current position comes out unchanged on `pos_o`. The decoder uses it for read-back and for the command that captures the position into a data register. The tap select does not follow a change at once. It follows after a fixed settling delay of `SETTLE_CYCLES` clocks, which stands in for the wiper response time. The serial clock and data inputs are assumed to be already synchronous to `clk`.

Top module: `wiper_pos_reg`

## Requirements
- R1: While `rst_n` is low the position is 00h and the tap select has only bit 0 set.
- R2: On the first clock edge after `rst_n` goes high, the position loads bank-0 register 0, which is bits [7:0] of `dr_bank0_i`.
- R3: A clock edge with `wr_en_i` high loads `wr_data_i` into the position.
- R4: A clock edge with `xfr_en_i` high loads bank-0 register n, where n is `xfr_sel_i` and register n is bits [8n+7:8n] of `dr_bank0_i`.
- R5: While `step_mode_i` is high, each low-to-high change of `sck_i` moves the position one step. The step is up by one when `si_i` is 1 and down by one when it is 0. Holding `sck_i` high gives only one step.
- R6: While `step_mode_i` is low, `sck_i` and `si_i` have no effect on the position.
- R7: Stepping up at FFh leaves FFh, and stepping down at 00h leaves 00h. There is no wrap-around.
- R8: When several sources act in the same cycle, only one of them takes effect. The order of precedence is power-up recall, then direct write, then transfer, then step.
- R9: `tap_o` always has exactly one bit set. That bit's index equals the settled position, so 00h gives bit 0 and FFh gives bit 255.
- R10: `pos_o` shows a new value one clock edge after the load. `tap_o` reflects that value `SETTLE_CYCLES` edges after the position changed. A new change restarts the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dr_bank0_i | input | 32 | The four bank-0 data registers; register n is bits [8n+7:8n] |
| wr_en_i | input | 1 | Direct write request |
| wr_data_i | input | 8 | Byte for a direct write |
| xfr_en_i | input | 1 | Transfer request from a bank-0 register |
| xfr_sel_i | input | 2 | Register index used by a transfer |
| step_mode_i | input | 1 | Step command is active |
| sck_i | input | 1 | Serial clock, already synchronous to `clk` |
| si_i | input | 1 | Step direction: 1 means up, 0 means down |
| pos_o | output | 8 | Current position, for read-back and capture |
| tap_o | output | 256 | One-hot tap select after the settling delay |

## Verification
Two pairs of sources can act in the same cycle. A direct write can meet a transfer, and a transfer can meet a serial clock step. Both pairs are driven in one cycle and the bench checks that only the higher-ranked source shows on `pos_o`. The recall and a write also collide: the bench holds a write request high while reset is released. It then expects the recalled byte after the first edge and the written byte after the second.

// File: rtl/wpr_pkg.sv
// Package: shared widths and the update-source encoding for the wiper
// position counter. Assumes an 8-bit position and four bank-0 registers.
package wpr_pkg;
    localparam int POS_W  = 8;
    localparam int NUM_DR = 4;

    // Which source updates the position in a given cycle.
    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_RECALL,
        SRC_WRITE,
        SRC_XFER,
        SRC_STEP
    } wpr_src_e;
endpackage

// File: rtl/wpr_sck_edge.sv
// Module: gives a one-cycle step pulse on each rising sck while step mode is
// active. Assumes sck_i is already synchronous to clk.
module wpr_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic en_i,
    output logic step_o
);
    logic sck_q;

    // Store the last sampled sck level so its rising edge can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_i;
    end

    // A step needs step mode and a low-to-high change of sck.
    always_comb step_o = en_i && sck_i && !sck_q;
endmodule

// File: rtl/wpr_next_pos.sv
// Module: picks the one source that acts this cycle, ranked fixed, and works
// out the next position. Steps stop at the ends of the range.
module wpr_next_pos #(
    parameter int POS_W = wpr_pkg::POS_W
) (
    input  logic [POS_W-1:0] cur_i,
    input  logic             recall_i,
    input  logic [POS_W-1:0] recall_data_i,
    input  logic             wr_en_i,
    input  logic [POS_W-1:0] wr_data_i,
    input  logic             xfr_en_i,
    input  logic [POS_W-1:0] xfr_data_i,
    input  logic             step_i,
    input  logic             up_i,
    output logic [POS_W-1:0] nxt_o
);
    import wpr_pkg::*;

    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_MIN = '0;

    wpr_src_e src;

    // Choose the source: recall, then write, then transfer, then step.
    always_comb begin
        if (recall_i)      src = SRC_RECALL;
        else if (wr_en_i)  src = SRC_WRITE;
        else if (xfr_en_i) src = SRC_XFER;
        else if (step_i)   src = SRC_STEP;
        else               src = SRC_HOLD;
    end

    // Work out the next position from the chosen source.
    always_comb begin
        case (src)
            SRC_RECALL: nxt_o = recall_data_i;
            SRC_WRITE:  nxt_o = wr_data_i;
            SRC_XFER:   nxt_o = xfr_data_i;
            SRC_STEP: begin
                if (up_i) nxt_o = (cur_i == POS_MAX) ? cur_i : cur_i + 1'b1;
                else      nxt_o = (cur_i == POS_MIN) ? cur_i : cur_i - 1'b1;
            end
            default:    nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/wpr_settle.sv
// Module: delays the position seen by the tap decoder by SETTLE cycles after
// each change; SETTLE of 0 gives a direct path. A new change restarts the wait.
module wpr_settle #(
    parameter int POS_W  = wpr_pkg::POS_W,
    parameter int SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_i,
    input  logic             chg_i,
    output logic [POS_W-1:0] pos_o
);
    generate
        if (SETTLE == 0) begin : g_direct
            assign pos_o = pos_i;
        end else begin : g_delay
            localparam int CNT_W = $clog2(SETTLE + 1);
            logic [CNT_W-1:0] cnt_q;
            logic [POS_W-1:0] hold_q;

            // Count down after a change, then pass the settled position on.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    hold_q <= '0;
                end else if (chg_i) begin
                    cnt_q  <= CNT_W'(SETTLE);
                end else if (cnt_q == CNT_W'(1)) begin
                    cnt_q  <= '0;
                    hold_q <= pos_i;
                end else if (cnt_q != '0) begin
                    cnt_q  <= cnt_q - 1'b1;
                end
            end

            assign pos_o = hold_q;
        end
    endgenerate
endmodule

// File: rtl/wpr_tap_decode.sv
// Module: turns a binary position into a one-hot select of 2**POS_W taps.
module wpr_tap_decode #(
    parameter int POS_W = wpr_pkg::POS_W
) (
    input  logic [POS_W-1:0]        pos_i,
    output logic [(1<<POS_W)-1:0]   tap_o
);
    localparam int NUM_TAPS = 1 << POS_W;

    generate
        for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
            // Each tap is on only when the position equals its index.
            assign tap_o[t] = (pos_i == POS_W'(t));
        end
    endgenerate
endmodule

// File: rtl/wiper_pos_reg.sv
// Module: wiper position counter. It recalls bank-0 register 0 on the first
// clock after reset and then takes direct writes, transfers and single steps.
// It drives a settled one-hot tap select. Assumes the serial inputs are
// synchronous to clk and the request strobes come from the command decoder.
module wiper_pos_reg #(
    parameter int POS_W         = wpr_pkg::POS_W,
    parameter int NUM_DR        = wpr_pkg::NUM_DR,
    parameter int SETTLE_CYCLES = 4,
    localparam int SEL_W        = $clog2(NUM_DR),
    localparam int NUM_TAPS     = 1 << POS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_DR*POS_W-1:0] dr_bank0_i,
    input  logic                    wr_en_i,
    input  logic [POS_W-1:0]        wr_data_i,
    input  logic                    xfr_en_i,
    input  logic [SEL_W-1:0]        xfr_sel_i,
    input  logic                    step_mode_i,
    input  logic                    sck_i,
    input  logic                    si_i,
    output logic [POS_W-1:0]        pos_o,
    output logic [NUM_TAPS-1:0]     tap_o
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_d;
    logic [POS_W-1:0] settled;
    logic             recall_q;
    logic             step;
    logic [POS_W-1:0] dr_arr [NUM_DR];

    generate
        for (genvar g = 0; g < NUM_DR; g++) begin : g_dr
            assign dr_arr[g] = dr_bank0_i[g*POS_W +: POS_W];
        end
    endgenerate

    wpr_sck_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_i),
        .en_i   (step_mode_i),
        .step_o (step)
    );

    wpr_next_pos #(.POS_W(POS_W)) u_next (
        .cur_i         (pos_q),
        .recall_i      (recall_q),
        .recall_data_i (dr_arr[0]),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .xfr_en_i      (xfr_en_i),
        .xfr_data_i    (dr_arr[xfr_sel_i]),
        .step_i        (step),
        .up_i          (si_i),
        .nxt_o         (pos_d)
    );

    // Hold the position and the one-shot recall flag set by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= '0;
            recall_q <= 1'b1;
        end else begin
            pos_q    <= pos_d;
            recall_q <= 1'b0;
        end
    end

    wpr_settle #(.POS_W(POS_W), .SETTLE(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_i (pos_q),
        .chg_i (pos_d != pos_q),
        .pos_o (settled)
    );

    wpr_tap_decode #(.POS_W(POS_W)) u_dec (
        .pos_i (settled),
        .tap_o (tap_o)
    );

    assign pos_o = pos_q;
endmodule

// File: rtl/wpr_chk.sv
// Checker: temporal properties of the wiper position counter, bound to every
// instance of the top module.
module wpr_chk #(
    parameter int POS_W  = 8,
    parameter int NUM_DR = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    recall_q,
    input logic [NUM_DR*POS_W-1:0] dr_bank0_i,
    input logic                    wr_en_i,
    input logic [POS_W-1:0]        wr_data_i,
    input logic                    xfr_en_i,
    input logic                    step_mode_i,
    input logic                    sck_i,
    input logic                    si_i,
    input logic [POS_W-1:0]        pos_o,
    input logic [(1<<POS_W)-1:0]   tap_o
);
    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    // R2: the first edge after reset loads register 0.
    a_r2_recall: assert property (@(posedge clk) disable iff (!rst_n)
        recall_q |=> pos_o == $past(dr_bank0_i[POS_W-1:0]));

    // R3 and R8: a write outranks transfer and step.
    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_q && wr_en_i |=> pos_o == $past(wr_data_i));

    // R6: with no request and step mode off, the position holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_q && !wr_en_i && !xfr_en_i && !step_mode_i |=> $stable(pos_o));

    // R7: no wrap at the top end.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_q && !wr_en_i && !xfr_en_i && step_mode_i && sck_i && si_i
        && pos_o == TOP |=> pos_o == TOP);

    // R7: no wrap at the bottom end.
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_q && !wr_en_i && !xfr_en_i && step_mode_i && sck_i && !si_i
        && pos_o == '0 |=> pos_o == '0);

    // R9: exactly one tap is on.
    a_r9_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_o) == 1);
endmodule

bind wiper_pos_reg wpr_chk #(.POS_W(POS_W), .NUM_DR(NUM_DR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .recall_q    (recall_q),
    .dr_bank0_i  (dr_bank0_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .xfr_en_i    (xfr_en_i),
    .step_mode_i (step_mode_i),
    .sck_i       (sck_i),
    .si_i        (si_i),
    .pos_o       (pos_o),
    .tap_o       (tap_o)
);

// File: tb/wiper_pos_reg_tb.sv
// Bench for the wiper position counter: a vector table of operations and
// expected positions, then directed tests for reset, precedence and ends.
module wiper_pos_reg_tb_top;
    localparam int SETTLE = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  dr_bank0 = {8'h80, 8'hFE, 8'h01, 8'h5A};
    logic         wr_en = 1'b0;
    logic [7:0]   wr_data = '0;
    logic         xfr_en = 1'b0;
    logic [1:0]   xfr_sel = '0;
    logic         step_mode = 1'b0;
    logic         sck = 1'b0;
    logic         si = 1'b0;
    logic [7:0]   pos;
    logic [255:0] tap;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wiper_pos_reg #(.SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .dr_bank0_i(dr_bank0),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .xfr_en_i(xfr_en),
        .xfr_sel_i(xfr_sel), .step_mode_i(step_mode), .sck_i(sck),
        .si_i(si), .pos_o(pos), .tap_o(tap)
    );

    // Operation codes: 0 write, 1 transfer, 2 step up, 3 step down.
    // Each entry is {op, argument, expected position}.
    localparam logic [17:0] VEC [13] = '{
        {2'd0, 8'h10, 8'h10},   // R3
        {2'd2, 8'h00, 8'h11},   // R5 up
        {2'd3, 8'h00, 8'h10},   // R5 down
        {2'd1, 8'h01, 8'h01},   // R4 register 1
        {2'd3, 8'h00, 8'h00},   // R5
        {2'd3, 8'h00, 8'h00},   // R7 floor
        {2'd1, 8'h02, 8'hFE},   // R4 register 2
        {2'd2, 8'h00, 8'hFF},   // R5
        {2'd2, 8'h00, 8'hFF},   // R7 ceiling
        {2'd1, 8'h03, 8'h80},   // R4 register 3
        {2'd0, 8'h00, 8'h00},   // R3
        {2'd2, 8'h00, 8'h01},   // R5
        {2'd1, 8'h00, 8'h5A}    // R4 register 0
    };

    task automatic chk_pos(input string req, input logic [7:0] exp);
        n_chk++;
        if (pos !== exp) begin
            n_fail++;
            $display("FAIL %s: pos_o actual %02h expected %02h", req, pos, exp);
        end
    endtask

    task automatic chk_tap(input string req, input logic [7:0] exp);
        logic [255:0] want;
        want = 256'b1 << exp;
        n_chk++;
        if (tap !== want) begin
            n_fail++;
            $display("FAIL %s: tap_o actual %h expected %h", req, tap, want);
        end
    endtask

    task automatic clear_in();
        wr_en = 1'b0; xfr_en = 1'b0; step_mode = 1'b0; sck = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait_neg(3);
        chk_pos("R1", 8'h00);
        chk_tap("R1", 8'h00);

        // Release reset with a write held: recall first (R2), write next (R8).
        rst_n = 1'b1; wr_en = 1'b1; wr_data = 8'h33;
        wait_neg(1);
        chk_pos("R2", 8'h5A);
        wait_neg(1);
        chk_pos("R8 recall before write", 8'h33);
        clear_in();
        // The write restarted the wait; the tap moves SETTLE edges after it (R10).
        wait_neg(SETTLE - 1);
        chk_tap("R10 before settle", 8'h00);
        wait_neg(1);
        chk_tap("R10 after settle", 8'h33);

        // Walk the vector table.
        foreach (VEC[v]) begin
            wait_neg(1);
            case (VEC[v][17:16])
                2'd0: begin wr_en = 1'b1; wr_data = VEC[v][15:8]; end
                2'd1: begin xfr_en = 1'b1; xfr_sel = VEC[v][9:8]; end
                2'd2: begin step_mode = 1'b1; sck = 1'b1; si = 1'b1; end
                default: begin step_mode = 1'b1; sck = 1'b1; si = 1'b0; end
            endcase
            wait_neg(1);
            chk_pos("R3/R4/R5/R7 vector", VEC[v][7:0]);
            clear_in();
        end

        // R8: transfer and step in one cycle, so the transfer wins.
        wait_neg(1);
        xfr_en = 1'b1; xfr_sel = 2'd1; step_mode = 1'b1; sck = 1'b1; si = 1'b1;
        wait_neg(1);
        chk_pos("R8 transfer over step", 8'h01);
        clear_in();

        // R8: write and transfer in one cycle, so the write wins.
        wait_neg(1);
        wr_en = 1'b1; wr_data = 8'h77; xfr_en = 1'b1; xfr_sel = 2'd2;
        wait_neg(1);
        chk_pos("R8 write over transfer", 8'h77);
        clear_in();

        // R5: sck held high for three cycles gives a single step.
        wait_neg(1);
        step_mode = 1'b1; si = 1'b1; sck = 1'b1;
        wait_neg(3);
        chk_pos("R5 one step per pulse", 8'h78);
        sck = 1'b0;
        wait_neg(1);
        step_mode = 1'b0;

        // R6: sck pulses with step mode off do nothing.
        for (int p = 0; p < 3; p++) begin
            wait_neg(1); sck = 1'b1; si = p[0];
            wait_neg(1); sck = 1'b0;
        end
        wait_neg(1);
        chk_pos("R6 steps ignored", 8'h78);

        // R9: both ends of the tap range.
        wr_en = 1'b1; wr_data = 8'hFF;
        wait_neg(1);
        clear_in();
        wait_neg(SETTLE);
        chk_tap("R9 high end", 8'hFF);
        wr_en = 1'b1; wr_data = 8'h00;
        wait_neg(1);
        clear_in();
        wait_neg(SETTLE);
        chk_tap("R9 low end", 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule